// File: doc/BRIEF.md
# Shared-Timer Input Debounce Unit

This block cleans up a bank of slow external inputs before they reach data reads and edge or level interrupt logic. Each input first passes a two-flop synchronizer. It then either goes straight to the output or passes through a stability filter. The filter changes the output only after the input has held a new value for a programmed number of clock cycles.

There are three period timers, and every pin of the bank shares them. Each pin chooses one timer, or no filtering, through a 2-bit code. The two bits of a pin's code live in two separate select registers at the same bit position. Software writes the registers through a simple write port. Changing a timer's period changes the filtering of every pin that uses that timer.

Top module: `dbn_unit`

## Requirements
- R1: While reset is low and after it is released, every select bit and every period is zero, so the output is all zero during reset and every pin runs unfiltered after it.
- R2: The periods of timers 1, 2 and 3 are written at byte addresses 0x50, 0x54 and 0x58. A write to any address other than these and the two select addresses changes no state.
- R3: The code for pin n is {bit n of the register at 0x00, bit n of the register at 0x04}. The first register gives the high bit and the second the low bit. Code 1, 2 or 3 picks timer 1, 2 or 3, and code 0 means unfiltered.
- R4: An unfiltered pin's output takes a new input value on the third rising clock edge after the input changes.
- R5: For a filtered pin whose timer period is P (P ≥ 1), the output takes a new input value on rising edge P+2 after the input changes, and not earlier.
- R6: If a filtered input returns to the output's value before its period has passed, the output does not change, and the count starts again from zero.
- R7: A timer period of 0 behaves like a period of 1: the pin is not locked, and it has the same latency as an unfiltered pin.
- R8: Pins that pick the same timer all use its current period. Rewriting that period changes the latency of all of those pins.
- R9: Pins that pick different timers are filtered independently, each with the period of its own timer.
- R10: A filtered output changes only to the value its synchronized input holds, and the count is zero in the cycle after any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| pin_in | input | 32 | Raw asynchronous pin inputs |
| pin_out | output | 32 | Synchronized and debounced pin values |

## Verification
The bench measures each pin's latency edge by edge, so a filter that is off by one cycle in its count or in its synchronizer depth gives a wrong count. It swaps the two select registers' roles, using codes 1 and 2 with different periods; a design with the bit order reversed shows the latencies exchanged. A short glitch, held for fewer cycles than the period, tests the count restart: a filter that only pauses its count, and does not clear it, lets the glitch through. A period of zero and writes to unused addresses that sit next to the timer registers catch a design that locks up on zero or that decodes too few address bits.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  localparam int unsigned NTIMER = 3;
  localparam int unsigned CODE_W = 2;

  localparam logic [7:0] ADDR_SEL_HI = 8'h00;
  localparam logic [7:0] ADDR_SEL_LO = 8'h04;
  localparam logic [7:0] ADDR_TMR1   = 8'h50;
  localparam logic [7:0] ADDR_TMR2   = 8'h54;
  localparam logic [7:0] ADDR_TMR3   = 8'h58;

  typedef enum logic [CODE_W-1:0] {
    CODE_BYPASS = 2'd0,
    CODE_TMR1   = 2'd1,
    CODE_TMR2   = 2'd2,
    CODE_TMR3   = 2'd3
  } dbn_code_e;
endpackage

// File: rtl/dbn_regs.sv
module dbn_regs
  import dbn_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned PW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [7:0]                  addr,
  input  logic [DW-1:0]               wdata,
  output logic [NPINS-1:0]            sel_hi,
  output logic [NPINS-1:0]            sel_lo,
  output logic [NTIMER-1:0][PW-1:0]   period
);
  logic [NPINS-1:0]          sel_hi_q, sel_hi_d;
  logic [NPINS-1:0]          sel_lo_q, sel_lo_d;
  logic [NTIMER-1:0][PW-1:0] per_q, per_d;
  logic                      hi_en, lo_en;
  logic [NTIMER-1:0]         per_en;

  always_comb begin
    hi_en = we && (addr == ADDR_SEL_HI);
    lo_en = we && (addr == ADDR_SEL_LO);
    per_en[0] = we && (addr == ADDR_TMR1);
    per_en[1] = we && (addr == ADDR_TMR2);
    per_en[2] = we && (addr == ADDR_TMR3);
  end

  always_comb begin
    sel_hi_d = sel_hi_q;
    sel_lo_d = sel_lo_q;
    per_d    = per_q;
    if (hi_en) sel_hi_d = wdata[NPINS-1:0];
    if (lo_en) sel_lo_d = wdata[NPINS-1:0];
    for (int t = 0; t < NTIMER; t++) begin
      if (per_en[t]) per_d[t] = wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_q <= '0;
      sel_lo_q <= '0;
      per_q    <= '0;
    end else begin
      sel_hi_q <= sel_hi_d;
      sel_lo_q <= sel_lo_d;
      per_q    <= per_d;
    end
  end

  assign sel_hi = sel_hi_q;
  assign sel_lo = sel_lo_q;
  assign period = per_q;

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(per_q)); // R2
  AST_SEL_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_SEL_HI) |=> $stable(sel_lo_q)); // R3
  AST_SEL_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_SEL_LO) |=> $stable(sel_hi_q)); // R3
endmodule

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/dbn_filter.sv
module dbn_filter
  import dbn_pkg::*;
#(
  parameter int unsigned PW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [PW-1:0]     period,
  input  logic              din,
  output logic              dout
);
  logic          out_q, out_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW:0]   limit, cnt_inc;
  logic          bypass, upd_en;

  always_comb begin
    bypass  = (code == CODE_BYPASS);
    limit   = (period == '0) ? {{PW{1'b0}}, 1'b1} : {1'b0, period};
    cnt_inc = {1'b0, cnt_q} + 1'b1;
  end

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (bypass) begin
      out_d = din;
      cnt_d = '0;
    end else if (din == out_q) begin
      cnt_d = '0;
    end else if (cnt_inc >= limit) begin
      out_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[PW-1:0];
    end
    upd_en = (out_d != out_q) || (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_BYPASS) |=> (out_q == $past(din))); // R4
  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(din))); // R10
  AST_CNT_CLEAR_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (cnt_q == '0)); // R10
  AST_GLITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (din == out_q) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/dbn_unit.sv
module dbn_unit
  import dbn_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned PW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out
);
  logic                      rst_meta_q, rst_core_n;
  logic [NPINS-1:0]          sel_hi, sel_lo, pin_sync;
  logic [NTIMER-1:0][PW-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  dbn_regs #(.NPINS(NPINS), .PW(PW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .sel_hi(sel_hi), .sel_lo(sel_lo), .period(period)
  );

  dbn_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic [PW-1:0]     per_sel;
    always_comb begin
      code    = {sel_hi[n], sel_lo[n]};
      per_sel = (code == CODE_BYPASS) ? '0 : period[code - 1'b1];
    end
    dbn_filter #(.PW(PW)) u_filt (
      .clk(clk), .rst_n(rst_core_n), .code(code), .period(per_sel),
      .din(pin_sync[n]), .dout(pin_out[n])
    );
  end
endmodule

// File: tb/sim_dbn_unit.sv
module sim_dbn_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] sh_hi, sh_lo;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbn_unit u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
               .cfg_wdata(cfg_wdata), .pin_in(pin_in), .pin_out(pin_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_code(input int pin, input logic [1:0] c);
    sh_hi[pin] = c[1];
    sh_lo[pin] = c[0];
    wr(8'h00, sh_hi);
    wr(8'h04, sh_lo);
  endtask

  task automatic measure(input int pa, input int pb, output int la, output int lb);
    la = -1; lb = -1;
    pin_in[pa] = ~pin_in[pa];
    if (pb != pa) pin_in[pb] = ~pin_in[pb];
    for (int k = 1; k <= 300 && (la < 0 || lb < 0); k++) begin
      @(negedge clk);
      if (la < 0 && pin_out[pa] == pin_in[pa]) la = k;
      if (lb < 0 && pin_out[pb] == pin_in[pb]) lb = k;
    end
  endtask

  task automatic t_reset;
    int la, lb;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pin_in = 32'hFFFF_FFFF; sh_hi = '0; sh_lo = '0;
    repeat (4) @(negedge clk);
    chk("R1 output zero in reset", pin_out, 32'h0);
    pin_in = '0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 output zero after reset", pin_out, 32'h0);
    measure(0, 0, la, lb);
    chk("R1 unfiltered after reset", la, 3);
  endtask

  task automatic t_bypass;
    logic [31:0] prev;
    prev = pin_out;
    pin_in = 32'hA5C3_0F96;
    @(negedge clk); @(negedge clk);
    chk("R4 no change before third edge", pin_out, prev);
    @(negedge clk);
    chk("R4 pattern after third edge", pin_out, 32'hA5C3_0F96);
    pin_in = 32'h0;
    repeat (3) @(negedge clk);
    chk("R4 clear pattern", pin_out, 32'h0);
  endtask

  task automatic t_split;
    int la, lb;
    wr(8'h50, 3);
    wr(8'h54, 5);
    set_code(4, 2'd2);
    set_code(5, 2'd1);
    measure(4, 5, la, lb);
    chk("R3 high bit select picks timer 2", la, 7);
    chk("R3 low bit select picks timer 1", lb, 5);
  endtask

  task automatic t_filter;
    int la, lb;
    wr(8'h58, 4);
    set_code(2, 2'd1);
    set_code(3, 2'd3);
    measure(2, 3, la, lb);
    chk("R5 period 3 latency", la, 5);
    chk("R9 period 4 on other timer", lb, 6);
    measure(2, 3, la, lb);
    chk("R5 falling direction latency", la, 5);
  endtask

  task automatic t_bounce;
    int la, lb;
    wr(8'h50, 6);
    set_code(10, 2'd1);
    pin_in[10] = 1'b1;
    repeat (3) @(negedge clk);
    pin_in[10] = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pin_out[10] !== 1'b0) begin
        chk("R6 glitch suppressed", pin_out[10], 0);
        break;
      end
    end
    chk("R6 output held through glitch", pin_out[10], 0);
    measure(10, 10, la, lb);
    chk("R6 full period after restart", la, 8);
  endtask

  task automatic t_shared;
    int la, lb;
    wr(8'h54, 5);
    set_code(0, 2'd2);
    set_code(1, 2'd2);
    measure(0, 1, la, lb);
    chk("R8 shared pin a", la, 7);
    chk("R8 shared pin b", lb, 7);
    wr(8'h54, 9);
    measure(0, 1, la, lb);
    chk("R8 reprogram pin a", la, 11);
    chk("R8 reprogram pin b", lb, 11);
  endtask

  task automatic t_zero;
    int la, lb;
    wr(8'h58, 0);
    set_code(12, 2'd3);
    measure(12, 12, la, lb);
    chk("R7 period zero passes", la, 3);
    measure(12, 12, la, lb);
    chk("R7 period zero second edge", la, 3);
  endtask

  task automatic t_addr;
    int la, lb;
    wr(8'h5C, 32'hFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h4C, 32'h7);
    wr(8'h10, 32'hFFFF_FFFF);
    measure(12, 2, la, lb);
    chk("R2 timer 3 untouched by unused writes", la, 3);
    chk("R2 timer 1 untouched by unused writes", lb, 8);
    measure(7, 7, la, lb);
    chk("R2 selects untouched by unused writes", la, 3);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          total++; fails++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("%0d/%0d checks passed", total - fails, total);
          $finish;
        end
      end
    join_none
    t_reset();
    t_bypass();
    t_split();
    t_filter();
    t_bounce();
    t_shared();
    t_zero();
    t_addr();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule